// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause 22 management transactions toward an Ethernet PHY over a clock pin (MDC) and a bidirectional data pin (MDIO). The MDIO pin is split into an output value, an output enable and an input. A host raises a one-cycle start strobe together with a read/write select, a 5-bit PHY address, a register address and 16 bits of write data. The block then sends the whole frame without further help. It signals completion with a one-cycle done pulse, and on reads it presents the register contents on the read-data port in that same cycle.

MDC is derived from the system clock. The half-period length is computed from the system clock frequency and the highest MDC frequency the bus allows, rounded up, so MDC can never run too fast. Every frame begins with an extended run of ones. Reads send a short 16-bit command and then release the pin to collect the PHY's answer. Writes send a full 32-bit word and then release the pin for two idle clocks. A register address outside the 5-bit clause 22 space is refused at once, and the pins stay idle.

Top module: `mdio_frame_master`

## Requirements
- R1: MDC is low whenever the block is idle. Within a frame, each high and each low half of MDC lasts at least HALF_DIV system clocks, where HALF_DIV = ceil(CLK_HZ / (2 * MDC_MAX_HZ)), which is 25 with the default parameters.
- R2: Every accepted frame opens with 33 MDC rising edges during which MDIO is driven (enable high) with the value 1.
- R3: A read then drives 16 bits, MSB first, one per MDC rising edge: 1, 1, 0, 1, 1, 0, then PHY address bits 4..0, then register address bits 4..0.
- R4: After its command, a read releases MDIO (enable low) for 19 MDC rising edges and samples the pin once per edge. Read data bit 15 is the 3rd sample and bit 0 is the 18th sample. The 1st, 2nd and 19th samples are discarded. The read data is valid in the cycle of the done pulse.
- R5: A write drives 32 bits after the preamble, MSB first: 0, 1, 0, 1, PHY address bits 4..0, register address bits 4..0, 1, 0, then write data bits 15..0.
- R6: After its 32 bits, a write releases MDIO for exactly 2 more MDC rising edges and then signals done. A write frame has 67 rising edges and a read frame has 68.
- R7: MDIO output value and enable change only while MDC is low. They stay stable for the whole high half of each MDC cycle.
- R8: A request whose register address has any bit above bit 4 set produces done on the clock after it is accepted, with no MDC edge and no MDIO drive. A refused read returns 16'hFFFF.
- R9: Busy rises on the clock that accepts a start strobe and falls on the clock after the one-cycle done pulse. A start strobe seen while busy is high, including in the done cycle, is ignored.
- R10: After reset, MDC, MDIO enable, busy and done are low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request strobe |
| isRead | input | 1 | 1 = read transaction, 0 = write |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | REG_AW | Register address; only values below 32 are legal |
| wrData | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven when enabled |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO pin as seen by the block |

## Verification
The completion pulse and the acceptance of a new request can fall in the same clock. A strobe raised exactly in the done cycle must be dropped, not queued. The bench raises a legal start strobe on the clock where it sees done high. It then checks that busy falls on the next clock and that no MDC edge appears for several hundred cycles. A second case raises a strobe in the middle of a read frame and checks that the finished frame and its read data belong only to the first request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Protocol lengths, counted in MDC cycles
  localparam int PREAMBLE_BITS = 33;
  localparam int RD_CMD_BITS   = 16;
  localparam int WR_CMD_BITS   = 32;
  localparam int RD_TAIL_BITS  = 19;
  localparam int WR_TAIL_BITS  = 2;
  localparam int FRAME_W       = 32;
  localparam int DATA_W        = 16;
  localparam int CNT_W         = $clog2(PREAMBLE_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SHIFT,
    ST_RELEASE,
    ST_FINISH
  } mdioState_t;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic clkRun;     // MDC divider runs
    logic loadFrame;  // capture request into shifter
    logic shiftTx;    // advance command shifter
    logic sampleRx;   // take one synchronized sample
    logic drivePre;   // drive preamble ones
    logic driveTx;    // drive shifter MSB
    logic captureRd;  // update read data output
    logic badRd;      // capture all ones instead of samples
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        isRead,
  input  logic        regHigh,
  input  logic        riseTick,
  input  logic        bitEnd,
  output mdioStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  mdioState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             rdMode;
  logic             accept;
  logic             lastCmd;
  logic             lastTail;

  assign accept   = (state == ST_IDLE) && startReq;
  assign lastCmd  = rdMode ? (bitCnt == CNT_W'(RD_CMD_BITS - 1))
                           : (bitCnt == CNT_W'(WR_CMD_BITS - 1));
  assign lastTail = rdMode ? (bitCnt == CNT_W'(RD_TAIL_BITS - 1))
                           : (bitCnt == CNT_W'(WR_TAIL_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdMode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            rdMode <= isRead;
            bitCnt <= '0;
            state  <= regHigh ? ST_FINISH : ST_PRE;
          end
        end
        ST_PRE: begin
          if (bitEnd) begin
            if (bitCnt == CNT_W'(PREAMBLE_BITS - 1)) begin
              bitCnt <= '0;
              state  <= ST_SHIFT;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (bitEnd) begin
            if (lastCmd) begin
              bitCnt <= '0;
              state  <= ST_RELEASE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_RELEASE: begin
          if (bitEnd) begin
            if (lastTail) begin
              bitCnt <= '0;
              state  <= ST_FINISH;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.clkRun    = (state == ST_PRE) || (state == ST_SHIFT) || (state == ST_RELEASE);
    strobe.loadFrame = accept;
    strobe.shiftTx   = (state == ST_SHIFT) && bitEnd;
    // the final idle sample is never taken into the shifter
    strobe.sampleRx  = (state == ST_RELEASE) && rdMode && riseTick && !lastTail;
    strobe.drivePre  = (state == ST_PRE);
    strobe.driveTx   = (state == ST_SHIFT);
    strobe.badRd     = accept && regHigh && isRead;
    strobe.captureRd = strobe.badRd ||
                       ((state == ST_RELEASE) && rdMode && bitEnd && lastTail);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 25,
  parameter int PHY_AW   = 5,
  parameter int RA_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strobe,
  input  logic              isRead,
  input  logic [PHY_AW-1:0] phyAddr,
  input  logic [RA_W-1:0]   regLow,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              riseTick,
  output logic              bitEnd,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] rdData
);

  localparam int FULL_DIV = 2 * HALF_DIV;
  localparam int DIV_W    = (FULL_DIV > 1) ? $clog2(FULL_DIV) : 1;

  logic [DIV_W-1:0]   divCnt;
  logic               mdcQ;
  logic [FRAME_W-1:0] txShift;
  logic [1:0]         syncQ;
  logic [DATA_W-1:0]  rxShift;

  assign riseTick = strobe.clkRun && (divCnt == DIV_W'(HALF_DIV - 1));
  assign bitEnd   = strobe.clkRun && (divCnt == DIV_W'(FULL_DIV - 1));

  // MDC divider: low half first, then high half
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.clkRun) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (bitEnd) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (riseTick) mdcQ <= 1'b1;
    end
  end

  // Command shifter, MSB goes out first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.loadFrame) begin
      if (isRead) txShift <= {2'b11, 2'b01, 2'b10, phyAddr, regLow, {DATA_W{1'b0}}};
      else        txShift <= {2'b01, 2'b01, phyAddr, regLow, 2'b10, wrData};
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  // Input synchronizer and sample shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      syncQ <= {syncQ[0], mdioIn};
      if (strobe.sampleRx) rxShift <= {rxShift[DATA_W-2:0], syncQ[1]};
      if (strobe.captureRd) rdData <= strobe.badRd ? {DATA_W{1'b1}} : rxShift;
    end
  end

  assign mdc     = mdcQ;
  assign mdioOe  = strobe.drivePre || strobe.driveTx;
  assign mdioOut = strobe.drivePre || (strobe.driveTx && txShift[FRAME_W-1]);

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int REG_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              isRead,
  input  logic [4:0]        phyAddr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [15:0]       wrData,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int HALF_DIV = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  mdioStrobe_t strobe;
  logic        riseTick;
  logic        bitEnd;
  logic        regHigh;

  generate
    if (REG_AW > 5) begin : g_wideReg
      assign regHigh = |regAddr[REG_AW-1:5];
    end else begin : g_narrowReg
      assign regHigh = 1'b0;
    end
  endgenerate

  mdio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .isRead   (isRead),
    .regHigh  (regHigh),
    .riseTick (riseTick),
    .bitEnd   (bitEnd),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  mdio_dp #(
    .HALF_DIV (HALF_DIV),
    .PHY_AW   (5),
    .RA_W     (5)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .isRead   (isRead),
    .phyAddr  (phyAddr),
    .regLow   (regAddr[4:0]),
    .wrData   (wrData),
    .mdioIn   (mdioIn),
    .riseTick (riseTick),
    .bitEnd   (bitEnd),
    .mdc      (mdc),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .rdData   (rdData)
  );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int REG_AW     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [REG_AW-1:0] regAddr,
  input logic              busy,
  input logic              done,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe
);

  localparam int HALF_MIN = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  logic [31:0] runCnt;
  logic        mdcPrev;
  logic        badAddr;

  assign badAddr = (regAddr >> 5) != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      mdcPrev <= 1'b0;
    end else begin
      mdcPrev <= mdc;
      if (mdc != mdcPrev)    runCnt <= 32'd1;
      else if (runCnt != '1) runCnt <= runCnt + 1'b1;
    end
  end

  // R1: no clock activity while idle
  a_r1_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R1: each completed half lasted long enough
  a_r1_half_width: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mdc) || $fell(mdc)) |-> (runCnt >= 32'(HALF_MIN)));

  // R2: pin released when no frame is running
  a_r2_oe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  // R7: data held through the high half
  a_r7_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe)));

  // R8: refused address finishes on the next clock
  a_r8_bad_fast: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && badAddr) |=> done);

  // R9: done is a single pulse inside busy, busy ends after it
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind mdio_frame_master mdio_frame_master_chk #(
  .CLK_HZ     (CLK_HZ),
  .MDC_MAX_HZ (MDC_MAX_HZ),
  .REG_AW     (REG_AW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .regAddr  (regAddr),
  .busy     (busy),
  .done     (done),
  .mdc      (mdc),
  .mdioOut  (mdioOut),
  .mdioOe   (mdioOe)
);

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;

  localparam int HALF = 25;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq;
  logic        isRead;
  logic [4:0]  phyAddr;
  logic [7:0]  regAddr;
  logic [15:0] wrData;
  logic        mdioIn;
  logic        busy, done, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;

  always #4 clk = ~clk;

  mdio_frame_master u_mdio_frame_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .busy(busy), .done(done), .rdData(rdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY model: records each rising edge, answers reads
  int          riseCnt  = 0;
  int          frameBase = 0;
  logic [15:0] phyData  = 16'h0;
  logic [1:0]  seen [0:79];

  always @(posedge mdc) begin
    int rel;
    rel = riseCnt - frameBase;
    if (rel >= 0 && rel < 80) seen[rel] = {mdioOe, mdioOut};
    riseCnt = riseCnt + 1;
    rel = rel + 1;
    #2;
    mdioIn = (rel >= 51 && rel <= 66) ? phyData[66-rel] : 1'b1;
  end

  // MDC half-width monitor
  int   shortRuns = 0;
  int   runLen    = 0;
  logic prevMdc   = 1'b0;
  always @(negedge clk) begin
    if (mdc !== prevMdc) begin
      if (runLen < HALF) shortRuns = shortRuns + 1;
      runLen = 1;
    end else begin
      runLen = runLen + 1;
    end
    prevMdc = mdc;
  end

  function automatic logic [1:0] slotExp(input int i, input bit rd, input logic [4:0] p,
                                         input logic [4:0] r, input logic [15:0] d);
    logic [15:0] c16;
    logic [31:0] c32;
    c16 = {6'b110110, p, r};
    c32 = {4'b0101, p, r, 2'b10, d};
    if (i < 33) return 2'b11;
    if (rd) return (i < 49) ? {1'b1, c16[48-i]} : 2'b00;
    return (i < 65) ? {1'b1, c32[64-i]} : 2'b00;
  endfunction

  task automatic checkFrame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d);
    int badIdx;
    logic [1:0] e;
    badIdx = -1;
    for (int i = 0; i < (rd ? 68 : 67); i++) begin
      e = slotExp(i, rd, p, r, d);
      if (badIdx < 0 && (seen[i][1] !== e[1] || (e[1] && seen[i][0] !== e[0]))) badIdx = i;
    end
    if (badIdx < 0) begin
      check(1, "R2", "frame", 0, 0);
    end else if (badIdx < 33) begin
      check(0, "R2", $sformatf("preamble slot %0d", badIdx), seen[badIdx], 2'b11);
    end else begin
      e = slotExp(badIdx, rd, p, r, d);
      check(0, rd ? "R3/R4" : "R5/R6", $sformatf("slot %0d", badIdx), seen[badIdx], e);
    end
  endtask

  task automatic waitDone(input bit pulseAtDone);
    int cyc;
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (pulseAtDone) begin
      startReq = 1'b1; isRead = 1'b0; phyAddr = 5'd3; regAddr = 8'd2; wrData = 16'h1234;
    end
  endtask

  task automatic runTxn(input bit rd, input logic [4:0] p, input logic [7:0] r,
                        input logic [15:0] d);
    bit bad;
    int sr0;
    bad = (r > 8'd31);
    frameBase = riseCnt;
    sr0 = shortRuns;
    phyData = d;
    @(negedge clk);
    startReq = 1'b1; isRead = rd; phyAddr = p; regAddr = r; wrData = d;
    @(negedge clk);
    startReq = 1'b0;
    if (bad) begin
      check(done === 1'b1, "R8", "done one clock after refused start", done, 1);
      if (rd) check(rdData === 16'hFFFF, "R8", "refused read data", rdData, 16'hFFFF);
      @(negedge clk);
      check(riseCnt == frameBase && !mdioOe, "R8", "bus stayed idle", riseCnt - frameBase, 0);
      check(!busy && !done, "R9", "idle after refused request", {busy, done}, 0);
      return;
    end
    check(busy === 1'b1, "R9", "busy after accept", busy, 1);
    waitDone(0);
    check(done === 1'b1, "R9", "done seen", done, 1);
    if (rd) check(rdData === d, "R4", "read data at done", rdData, d);
    @(negedge clk);
    check(!done && !busy, "R9", "done single and busy falls", {busy, done}, 0);
    check(riseCnt - frameBase == (rd ? 68 : 67), "R6", "rising edge count",
          riseCnt - frameBase, rd ? 68 : 67);
    check(shortRuns == sr0, "R1", "MDC half too short", shortRuns - sr0, 0);
    checkFrame(rd, p, r[4:0], d);
  endtask

  // isRead, phyAddr, regAddr, data
  localparam logic [29:0] VEC [0:5] = '{
    {1'b0, 5'd1,  8'd0,  16'h1200},
    {1'b0, 5'd31, 8'd31, 16'hA5C3},
    {1'b1, 5'd0,  8'd1,  16'h796D},
    {1'b1, 5'd31, 8'd31, 16'h8001},
    {1'b1, 5'd10, 8'd4,  16'h0000},
    {1'b0, 5'd21, 8'd10, 16'hFFFF}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL R9 watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int r0;
    rstN = 1'b0; startReq = 1'b0; isRead = 1'b0; phyAddr = '0; regAddr = '0;
    wrData = '0; mdioIn = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(!mdc && !mdioOe, "R10", "mdc/oe in reset", {mdc, mdioOe}, 0);
    check(!busy && !done, "R10", "busy/done in reset", {busy, done}, 0);
    check(rdData === 16'h0, "R10", "read data in reset", rdData, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!mdc && !busy, "R1", "idle mdc low", {mdc, busy}, 0);

    for (int v = 0; v < 6; v++) begin
      runTxn(VEC[v][29], VEC[v][28:24], VEC[v][23:16], VEC[v][15:0]);
    end

    // R8: out-of-range register addresses
    runTxn(1'b1, 5'd2, 8'h20, 16'h0000);
    runTxn(1'b0, 5'd2, 8'h80, 16'hBEEF);

    // R9: strobe in mid-frame is ignored
    frameBase = riseCnt;
    phyData = 16'h3C96;
    @(negedge clk);
    startReq = 1'b1; isRead = 1'b1; phyAddr = 5'd5; regAddr = 8'd3; wrData = 16'h0;
    @(negedge clk);
    startReq = 1'b0;
    repeat (600) @(negedge clk);
    startReq = 1'b1; isRead = 1'b0; phyAddr = 5'd17; regAddr = 8'd9; wrData = 16'h5555;
    @(negedge clk);
    startReq = 1'b0;
    // R9: strobe in the done cycle is ignored as well
    waitDone(1);
    check(rdData === 16'h3C96, "R9", "read data unaffected by busy strobe", rdData, 16'h3C96);
    @(negedge clk);
    startReq = 1'b0;
    check(!busy, "R9", "done-cycle strobe not accepted", busy, 0);
    check(riseCnt - frameBase == 68, "R9", "single frame length", riseCnt - frameBase, 68);
    checkFrame(1'b1, 5'd5, 5'd3, 16'h3C96);
    r0 = riseCnt;
    repeat (300) @(negedge clk);
    check(riseCnt == r0 && !busy, "R9", "no frame after ignored strobes", riseCnt - r0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule